// File: doc/BRIEF.md
# Three-Axis Direction-Change Detector

This block watches a stream of three-axis acceleration samples and raises an interrupt whenever the orientation pattern of the sensor changes. Each axis sample is sorted into one of three bands. It is "high" when it is above an external threshold, "low" when it is below an internal threshold, and "neutral" otherwise. The three-axis band pattern of each sample is compared with the pattern stored from the sample before it. A difference on any enabled axis sets the source's active flag.

A source register reports the active flag and, for each axis, a low flag and a high flag. The interrupt line follows the active flag when the interrupt enable is set. There are two update modes. In pass-through mode the source register is rewritten on every valid sample. In latched mode, once an event has been captured, the source register is frozen until a separate acknowledge-read strobe clears it.

Top module: `dircd_top`

## Requirements
- R1: After reset, src_active, src_lo, src_hi and irq are all 0, and the stored band pattern of every axis is neutral.
- R2: On a sample, an axis is high when its value is strictly greater than thr_ext, and low when its value is strictly less than thr_int and it is not high. A value equal to a threshold is neutral. The flags appear in src_lo/src_hi, with bit 0 for X, bit 1 for Y and bit 2 for Z, in the cycle after smp_vld. An axis never shows low and high together.
- R3: An axis whose axis_en bit is 0 (bit 0 = X, 1 = Y, 2 = Z) reports 0 in src_lo and src_hi, and a band change on that axis does not set src_active. Its band is still stored.
- R4: src_active is set to 1 by a sample whose band on any enabled axis differs from the band stored from the previous sample. The first sample after reset is compared against neutral.
- R5: With latch_en = 0, every valid sample rewrites src_active, src_lo and src_hi, and ack_rd has no effect.
- R6: With latch_en = 1, once src_active is 1 the source register holds its value through further samples until ack_rd is pulsed. ack_rd alone clears the register to 0 in the next cycle. A sample arriving together with ack_rd is evaluated and written in place of the clear.
- R7: irq equals src_active when irq_en is 1, and it stays 0 when irq_en is 0.
- R8: In a cycle without smp_vld, neither the source register nor the stored band pattern changes, except for the clear in R6.
- R9: Samples and thresholds are compared as signed two's-complement values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_vld | input | 1 | One-cycle strobe: a new sample is present on smp_x/smp_y/smp_z |
| smp_x | input | 16 | X-axis sample, signed |
| smp_y | input | 16 | Y-axis sample, signed |
| smp_z | input | 16 | Z-axis sample, signed |
| thr_int | input | 16 | Internal (lower) threshold, signed |
| thr_ext | input | 16 | External (upper) threshold, signed |
| axis_en | input | 3 | Per-axis enable for detection and flags |
| irq_en | input | 1 | Interrupt line enable |
| latch_en | input | 1 | Select latched mode |
| ack_rd | input | 1 | Acknowledge-read strobe, clears a latched event |
| src_active | output | 1 | Band pattern changed on an enabled axis |
| src_lo | output | 3 | Per-axis below-internal-threshold flags |
| src_hi | output | 3 | Per-axis above-external-threshold flags |
| irq | output | 1 | Interrupt request |

## Verification
Every source result is registered once. The flags and active bit for a sample, and the clear caused by an acknowledge, are therefore due exactly one clock after the strobe. irq is a gate on that register and arrives in the same cycle. The bench drives each strobe on a falling edge, removes it on the next falling edge, and samples the outputs at that second falling edge, which is half a period after the register has loaded. Hold behaviour is checked by idling for several cycles and sampling again.

// File: rtl/dircd_pkg.sv
package dircd_pkg;

    // Band of one axis sample relative to the two thresholds
    typedef enum logic [1:0] {
        BAND_NEUTRAL = 2'b00,
        BAND_LOW     = 2'b01,
        BAND_HIGH    = 2'b10
    } band_e;

endpackage

// File: rtl/dircd_band.sv
module dircd_band
    import dircd_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic [DW-1:0] sample,
    input  logic [DW-1:0] thr_int,
    input  logic [DW-1:0] thr_ext,
    output band_e         band
);

    logic above_ext;
    logic below_int;

    always_comb begin
        above_ext = $signed(sample) > $signed(thr_ext);
        below_int = $signed(sample) < $signed(thr_int);
        if (above_ext)
            band = BAND_HIGH;
        else if (below_int)
            band = BAND_LOW;
        else
            band = BAND_NEUTRAL;
    end

endmodule

// File: rtl/dircd_history.sv
module dircd_history #(
    parameter int NAX = 3,
    localparam int VW = 2 * NAX
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           smp_vld,
    input  logic [VW-1:0]  band_vec,
    input  logic [NAX-1:0] axis_en,
    output logic           changed
);

    typedef struct packed {
        logic [VW-1:0] prev;
    } hist_t;

    hist_t         hist_d, hist_q;
    logic [VW-1:0] en_mask;

    always_comb begin
        for (int i = 0; i < NAX; i++) begin
            en_mask[2*i]   = axis_en[i];
            en_mask[2*i+1] = axis_en[i];
        end
        changed = |((band_vec ^ hist_q.prev) & en_mask);
        hist_d  = hist_q;
        if (smp_vld)
            hist_d.prev = band_vec;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            hist_q <= '0;
        else
            hist_q <= hist_d;
    end

    AST_HIST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !smp_vld |=> $stable(hist_q)); // R8

endmodule

// File: rtl/dircd_source.sv
module dircd_source #(
    parameter int NAX = 3
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           smp_vld,
    input  logic           changed,
    input  logic [NAX-1:0] lo_raw,
    input  logic [NAX-1:0] hi_raw,
    input  logic [NAX-1:0] axis_en,
    input  logic           latch_en,
    input  logic           ack_rd,
    output logic           act,
    output logic [NAX-1:0] lo,
    output logic [NAX-1:0] hi
);

    typedef struct packed {
        logic           act;
        logic [NAX-1:0] lo;
        logic [NAX-1:0] hi;
    } src_t;

    src_t src_d, src_q;
    logic ack_clr;
    logic frozen;

    always_comb begin
        ack_clr = latch_en && ack_rd;
        frozen  = latch_en && src_q.act && !ack_rd;
        src_d   = src_q;
        if (smp_vld && !frozen) begin
            src_d.act = changed;
            src_d.lo  = lo_raw & axis_en;
            src_d.hi  = hi_raw & axis_en;
        end else if (ack_clr) begin
            src_d = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            src_q <= '0;
        else
            src_q <= src_d;
    end

    assign act = src_q.act;
    assign lo  = src_q.lo;
    assign hi  = src_q.hi;

    AST_ACK_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        latch_en && ack_rd && !smp_vld |=> src_q == '0); // R6

    AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        latch_en && src_q.act && !ack_rd |=> $stable(src_q)); // R6

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !smp_vld && !(latch_en && ack_rd) |=> $stable(src_q)); // R8

    AST_DIS_AXIS: assert property (@(posedge clk) disable iff (!rst_n)
        smp_vld && !frozen |=> ((src_q.lo | src_q.hi) & ~$past(axis_en)) == '0); // R3

    AST_LOHI_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        (src_q.lo & src_q.hi) == '0); // R2

endmodule

// File: rtl/dircd_top.sv
module dircd_top
    import dircd_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          smp_vld,
    input  logic [DW-1:0] smp_x,
    input  logic [DW-1:0] smp_y,
    input  logic [DW-1:0] smp_z,
    input  logic [DW-1:0] thr_int,
    input  logic [DW-1:0] thr_ext,
    input  logic [2:0]    axis_en,
    input  logic          irq_en,
    input  logic          latch_en,
    input  logic          ack_rd,
    output logic          src_active,
    output logic [2:0]    src_lo,
    output logic [2:0]    src_hi,
    output logic          irq
);

    localparam int NAX = 3;
    localparam int VW  = 2 * NAX;

    logic [DW-1:0]  samples [NAX];
    band_e          band    [NAX];
    logic [VW-1:0]  band_vec;
    logic [NAX-1:0] lo_raw;
    logic [NAX-1:0] hi_raw;
    logic           changed;

    assign samples[0] = smp_x;
    assign samples[1] = smp_y;
    assign samples[2] = smp_z;

    for (genvar a = 0; a < NAX; a++) begin : g_axis
        dircd_band #(.DW(DW)) u_band (
            .sample  (samples[a]),
            .thr_int (thr_int),
            .thr_ext (thr_ext),
            .band    (band[a])
        );
        assign band_vec[2*a +: 2] = band[a];
        assign lo_raw[a] = (band[a] == BAND_LOW);
        assign hi_raw[a] = (band[a] == BAND_HIGH);
    end

    dircd_history #(.NAX(NAX)) u_hist (
        .clk      (clk),
        .rst_n    (rst_n),
        .smp_vld  (smp_vld),
        .band_vec (band_vec),
        .axis_en  (axis_en),
        .changed  (changed)
    );

    dircd_source #(.NAX(NAX)) u_src (
        .clk      (clk),
        .rst_n    (rst_n),
        .smp_vld  (smp_vld),
        .changed  (changed),
        .lo_raw   (lo_raw),
        .hi_raw   (hi_raw),
        .axis_en  (axis_en),
        .latch_en (latch_en),
        .ack_rd   (ack_rd),
        .act      (src_active),
        .lo       (src_lo),
        .hi       (src_hi)
    );

    assign irq = src_active && irq_en;

endmodule

// File: tb/sim_dircd_top.sv
module sim_dircd_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        smp_vld = 1'b0;
    logic [15:0] smp_x = '0, smp_y = '0, smp_z = '0;
    logic [15:0] thr_int = 16'(-100);
    logic [15:0] thr_ext = 16'd100;
    logic [2:0]  axis_en = 3'b111;
    logic        irq_en = 1'b1;
    logic        latch_en = 1'b0;
    logic        ack_rd = 1'b0;
    logic        src_active, irq;
    logic [2:0]  src_lo, src_hi;

    int total = 0;
    int bad = 0;

    always #4 clk = ~clk;

    dircd_top u0 (
        .clk(clk), .rst_n(rst_n), .smp_vld(smp_vld),
        .smp_x(smp_x), .smp_y(smp_y), .smp_z(smp_z),
        .thr_int(thr_int), .thr_ext(thr_ext), .axis_en(axis_en),
        .irq_en(irq_en), .latch_en(latch_en), .ack_rd(ack_rd),
        .src_active(src_active), .src_lo(src_lo), .src_hi(src_hi), .irq(irq)
    );

    function automatic logic [54:0] mk(int x, int y, int z, logic a,
                                       logic [2:0] lo, logic [2:0] hi);
        return {16'(x), 16'(y), 16'(z), a, lo, hi};
    endfunction

    // x, y, z, expected active, expected lo, expected hi (thr_int=-100, thr_ext=100)
    localparam int NV = 7;
    localparam logic [54:0] TBL [NV] = '{
        mk(0, 0, 0,                1'b0, 3'b000, 3'b000),
        mk(200, 0, 0,              1'b1, 3'b000, 3'b001),
        mk(200, 0, 0,              1'b0, 3'b000, 3'b001),
        mk(100, -100, 0,           1'b1, 3'b000, 3'b000),
        mk(0, -101, 101,           1'b1, 3'b010, 3'b100),
        mk(-32768, -5000, 32767,   1'b1, 3'b011, 3'b100),
        mk(-32768, -5000, 32767,   1'b0, 3'b011, 3'b100)
    };

    task automatic chk(string tag, logic [15:0] got, logic [15:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, got, exp);
        end
    endtask

    task automatic chk_src(string tag, logic a, logic [2:0] lo, logic [2:0] hi);
        chk({tag, " active"}, 16'(src_active), 16'(a));
        chk({tag, " lo"}, 16'(src_lo), 16'(lo));
        chk({tag, " hi"}, 16'(src_hi), 16'(hi));
    endtask

    task automatic sample(int x, int y, int z, logic ack);
        @(negedge clk);
        smp_x = 16'(x); smp_y = 16'(y); smp_z = 16'(z);
        smp_vld = 1'b1; ack_rd = ack;
        @(negedge clk);
        smp_vld = 1'b0; ack_rd = 1'b0;
    endtask

    initial begin
        #800000;
        bad++;
        total++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk_src("R1 reset", 1'b0, 3'b000, 3'b000);
        chk("R1 reset irq", 16'(irq), 16'd0);
        rst_n = 1'b1;

        // Table walk: R2 R4 R5 R9 in pass-through mode, irq_en=1 (R7)
        for (int i = 0; i < NV; i++) begin
            logic [54:0] v;
            v = TBL[i];
            sample(int'($signed(v[54:39])), int'($signed(v[38:23])),
                   int'($signed(v[22:7])), 1'b0);
            chk_src($sformatf("R2/R4/R9 vec%0d", i), v[6], v[5:3], v[2:0]);
            chk($sformatf("R7 vec%0d irq", i), 16'(irq), 16'(v[6]));
        end

        // R8: inputs move without strobe, nothing changes
        @(negedge clk);
        smp_x = 16'd900; smp_y = 16'd900; smp_z = 16'(-900);
        repeat (3) @(negedge clk);
        chk_src("R8 idle", 1'b0, 3'b011, 3'b100);

        // R5: acknowledge ignored in pass-through mode
        @(negedge clk); ack_rd = 1'b1;
        @(negedge clk); ack_rd = 1'b0;
        chk_src("R5 ack ignored", 1'b0, 3'b011, 3'b100);

        // R7: interrupt gated off
        irq_en = 1'b0;
        sample(0, 0, 0, 1'b0);
        chk_src("R7 gated", 1'b1, 3'b000, 3'b000);
        chk("R7 irq off", 16'(irq), 16'd0);

        // R3: disabled X axis
        irq_en = 1'b1;
        axis_en = 3'b110;
        sample(500, 0, 0, 1'b0);
        chk_src("R3 disabled axis", 1'b0, 3'b000, 3'b000);
        chk("R3 irq", 16'(irq), 16'd0);
        axis_en = 3'b111;
        sample(500, 0, 0, 1'b0);
        chk_src("R3 band stored", 1'b0, 3'b000, 3'b001);

        // R6: latched mode
        latch_en = 1'b1;
        sample(0, 0, 0, 1'b0);
        chk_src("R6 capture", 1'b1, 3'b000, 3'b000);
        chk("R6 irq", 16'(irq), 16'd1);
        sample(0, 300, 0, 1'b0);
        chk_src("R6 frozen", 1'b1, 3'b000, 3'b000);
        @(negedge clk); ack_rd = 1'b1;
        @(negedge clk); ack_rd = 1'b0;
        chk_src("R6 ack clear", 1'b0, 3'b000, 3'b000);
        chk("R6 irq cleared", 16'(irq), 16'd0);
        sample(0, 300, -300, 1'b1);
        chk_src("R6 ack+sample", 1'b1, 3'b100, 3'b010);
        sample(0, 300, -300, 1'b1);
        chk_src("R6 ack+nochange", 1'b0, 3'b100, 3'b010);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule